// File: doc/BRIEF.md
# Memory-backed burst read slave

This block answers read requests on an AXI-style read-address and read-data channel pair. It takes one address handshake that carries an ID, a start byte address, a beat count minus one, a beat size and a burst type. It then streams the requested beats out of an internal word array. The slave works out the address of every beat itself, so the master presents only the start address.

Only one burst is in flight at a time. The address channel stays closed until the final beat has been handed over. Each beat is checked against the mapped range on its own, so a burst that runs off the end of the array returns decode errors from that beat onward. The read-data channel follows the usual valid/ready rule: a beat moves on a rising edge only when both sides are high, and while the master holds ready low the slave keeps the beat steady.

The array is read-only and its contents are a fixed function of the word index. It is written so that a block RAM can hold it. The result is a self-contained read target for an interconnect.

Top module: `burst_rd_slave`

## Requirements
- R1: During and right after the synchronous active-high reset, `ar_ready` is 1 and both `r_valid` and `r_last` are 0.
- R2: A request is taken on a rising edge where `ar_valid` and `ar_ready` are both 1. From the next cycle until the final beat's handshake, `ar_ready` is 0. In the cycle after that handshake, `ar_ready` is 1 again and `r_valid` is 0.
- R3: A request returns exactly `ar_len`+1 beats. `r_last` is 1 on the final beat and on no other.
- R4: The first beat is presented (`r_valid`=1) in the cycle right after the request is taken.
- R5: Burst type 1 (incrementing) adds 2^`ar_size` bytes to the address after each beat, modulo 2^AW. Type 3 is treated the same way. Every beat returns the whole array word at index address >> log2(DW/8), with no byte-lane steering.
- R6: Burst type 0 (fixed) uses the start address for every beat.
- R7: Burst type 2 (wrapping) takes `ar_len`+1 in {2,4,8,16} and a start address aligned to the beat size. The address increments as in R5 but wraps to the base of the aligned region of (`ar_len`+1)·2^`ar_size` bytes that holds the start address.
- R8: While `r_valid` is 1 and `r_ready` is 0, the next cycle keeps `r_valid` at 1 and holds `r_data`, `r_resp`, `r_last` and `r_id` unchanged.
- R9: A beat whose address is below DEPTH·DW/8 has `r_resp`=2'b00 (OKAY). Any other beat has `r_resp`=2'b11 (DECERR) and `r_data`=0. The check is made on each beat separately.
- R10: `r_id` on every beat equals the `ar_id` captured with the request.
- R11: Array word k (DW=32) holds (k·0x9E3779B1 mod 2^32) XOR 0xA5A50000. For wider words, 32-bit chunk c of word k uses index k·DW/32+c in that formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ar_valid | input | 1 | Read request offered |
| ar_ready | output | 1 | Slave can take a request |
| ar_id | input | IDW | Request tag |
| ar_addr | input | AW | Start byte address |
| ar_len | input | 8 | Beat count minus one |
| ar_size | input | 3 | log2 of bytes per beat |
| ar_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| r_valid | output | 1 | Beat presented |
| r_ready | input | 1 | Master takes the beat |
| r_id | output | IDW | Tag of the burst |
| r_data | output | DW | Beat data |
| r_resp | output | 2 | 00 OKAY, 11 DECERR |
| r_last | output | 1 | Final beat of the burst |

## Verification
The slave is driven with random bursts of every type, size and length. The start addresses fall both inside and past the mapped range, and the ready duty cycle varies, so address stepping, wrap arithmetic, stall holding and per-beat decode are each tried under stalls. Directed cases cover the points that random stimulus tells apart poorly. A full 256-beat incrementing burst that ends exactly at the top of the array shows the beat counter does not wrap early. An incrementing burst that crosses the top shows the decode switches in mid-burst. A four-beat wrap that starts near the top of its region separates wrapping from incrementing. Byte-sized incrementing and repeated fixed beats show that the word index comes from the byte address.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'd0,
    BT_INCR  = 2'd1,
    BT_WRAP  = 2'd2,
    BT_RSVD  = 2'd3
  } burst_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  // Content of one 32-bit chunk of the array, by chunk index.
  function automatic logic [31:0] fill_chunk(input int unsigned k);
    logic [31:0] p;
    p = k * 32'h9E3779B1;
    return p ^ 32'hA5A50000;
  endfunction
endpackage

// File: rtl/brs_addr_step.sv
`timescale 1ns/1ps
module brs_addr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    size,
  input  logic [1:0]    burst,
  input  logic [7:0]    len,
  output logic [AW-1:0] next
);
  import brs_pkg::*;

  logic [AW-1:0] step, incr, beats, span, mask, wrapped;

  always_comb begin
    step    = AW'(1) << size;
    incr    = cur + step;
    beats   = AW'(len) + AW'(1);
    span    = beats << size;
    mask    = span - AW'(1);
    wrapped = (cur & ~mask) | (incr & mask);
    case (burst_e'(burst))
      BT_FIXED: next = cur;
      BT_WRAP:  next = wrapped;
      default:  next = incr;
    endcase
  end
endmodule

// File: rtl/brs_rom.sv
`timescale 1ns/1ps
module brs_rom #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int IW   = $clog2(DEPTH),
  localparam int NCH  = DW / 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      for (int c = 0; c < NCH; c++) begin
        mem[k][c*32 +: 32] = brs_pkg::fill_chunk(k * NCH + c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) q <= mem[idx];
  end
endmodule

// File: rtl/burst_rd_slave.sv
`timescale 1ns/1ps
module burst_rd_slave #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IDW   = 4,
  parameter int DEPTH = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ar_valid,
  output logic           ar_ready,
  input  logic [IDW-1:0] ar_id,
  input  logic [AW-1:0]  ar_addr,
  input  logic [7:0]     ar_len,
  input  logic [2:0]     ar_size,
  input  logic [1:0]     ar_burst,
  output logic           r_valid,
  input  logic           r_ready,
  output logic [IDW-1:0] r_id,
  output logic [DW-1:0]  r_data,
  output logic [1:0]     r_resp,
  output logic           r_last
);
  import brs_pkg::*;

  localparam int BYTES = DW / 8;
  localparam int WS    = $clog2(BYTES);
  localparam int IW    = $clog2(DEPTH);
  localparam logic [AW:0] SPAN = (AW+1)'(DEPTH * BYTES);

  logic          busy;
  logic [AW-1:0] cur_q, next_addr, fetch_addr;
  logic [2:0]    size_q;
  logic [1:0]    burst_q;
  logic [7:0]    len_q, beat_q;
  logic          dec_q;
  logic          accept, hs, fetch, in_range;
  logic [DW-1:0] rom_q;

  assign ar_ready   = ~busy;
  assign accept     = ar_valid & ar_ready;
  assign hs         = r_valid & r_ready;
  assign fetch      = accept | (hs & ~r_last);
  assign fetch_addr = accept ? ar_addr : next_addr;
  assign in_range   = {1'b0, fetch_addr} < SPAN;

  brs_addr_step #(.AW(AW)) i_step (
    .cur   (cur_q),
    .size  (size_q),
    .burst (burst_q),
    .len   (len_q),
    .next  (next_addr)
  );

  brs_rom #(.DW(DW), .DEPTH(DEPTH)) i_rom (
    .clk (clk),
    .en  (fetch),
    .idx (fetch_addr[WS +: IW]),
    .q   (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      r_valid <= 1'b0;
      r_last  <= 1'b0;
      r_resp  <= RESP_OKAY;
      r_id    <= '0;
      dec_q   <= 1'b0;
      cur_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      len_q   <= '0;
      beat_q  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cur_q   <= ar_addr;
      size_q  <= ar_size;
      burst_q <= ar_burst;
      len_q   <= ar_len;
      beat_q  <= '0;
      r_id    <= ar_id;
      r_valid <= 1'b1;
      r_last  <= (ar_len == 8'd0);
      dec_q   <= ~in_range;
      r_resp  <= in_range ? RESP_OKAY : RESP_DECERR;
    end else if (hs) begin
      if (r_last) begin
        busy    <= 1'b0;
        r_valid <= 1'b0;
        r_last  <= 1'b0;
      end else begin
        cur_q  <= next_addr;
        beat_q <= beat_q + 8'd1;
        r_last <= ((beat_q + 8'd1) == len_q);
        dec_q  <= ~in_range;
        r_resp <= in_range ? RESP_OKAY : RESP_DECERR;
      end
    end
  end

  assign r_data = dec_q ? '0 : rom_q;
endmodule

// File: rtl/brs_chk.sv
`timescale 1ns/1ps
module brs_chk #(
  parameter int DW  = 32,
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           ar_valid,
  input logic           ar_ready,
  input logic [IDW-1:0] ar_id,
  input logic [7:0]     ar_len,
  input logic           r_valid,
  input logic           r_ready,
  input logic [IDW-1:0] r_id,
  input logic [DW-1:0]  r_data,
  input logic [1:0]     r_resp,
  input logic           r_last
);
  logic [7:0]     cnt, len_c;
  logic [IDW-1:0] id_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; len_c <= '0; id_c <= '0;
    end else if (ar_valid && ar_ready) begin
      cnt <= '0; len_c <= ar_len; id_c <= ar_id;
    end else if (r_valid && r_ready) begin
      cnt <= cnt + 8'd1;
    end
  end

  p_closed_r2: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> !ar_ready);
  p_reopen_r2: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && r_last) |=> (!r_valid && ar_ready));
  p_last_r3: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (r_last == (cnt == len_c)));
  p_first_r4: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready) |=> r_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp)
                               && $stable(r_last) && $stable(r_id)));
  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_resp == 2'b11) |-> (r_data == '0));
  p_code_r9: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (r_resp == 2'b00 || r_resp == 2'b11));
  p_tag_r10: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (r_id == id_c));
endmodule

bind burst_rd_slave brs_chk #(.DW(DW), .IDW(IDW)) i_chk (.*);

// File: tb/test_burst_rd_slave.sv
`timescale 1ns/1ps
module test_burst_rd_slave;
  localparam int AW = 16, DW = 32, IDW = 4, DEPTH = 256;
  localparam int TOP = DEPTH * 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ar_valid = 1'b0;
  logic           ar_ready;
  logic [IDW-1:0] ar_id = '0;
  logic [AW-1:0]  ar_addr = '0;
  logic [7:0]     ar_len = '0;
  logic [2:0]     ar_size = '0;
  logic [1:0]     ar_burst = '0;
  logic           r_valid;
  logic           r_ready = 1'b0;
  logic [IDW-1:0] r_id;
  logic [DW-1:0]  r_data;
  logic [1:0]     r_resp;
  logic           r_last;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  burst_rd_slave #(.AW(AW), .DW(DW), .IDW(IDW), .DEPTH(DEPTH)) i_burst_rd_slave (.*);

  function automatic logic [31:0] exp_word(input int unsigned k);
    logic [31:0] p;
    p = k * 32'h9E3779B1;
    return p ^ 32'hA5A50000;
  endfunction

  function automatic int exp_next(input int a, input int sz, input int bt, input int ln);
    int wb, base;
    if (bt == 0) return a;
    if (bt == 2) begin
      wb   = (ln + 1) << sz;
      base = a - (a % wb);
      return base + ((a + (1 << sz) - base) % wb);
    end
    return (a + (1 << sz)) & 32'hFFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input int id, input int addr, input int len,
                           input int sz, input int bt, input int rdy_pct);
    int ea, beat, guard;
    bit stalled;
    logic [DW-1:0] pd; logic [1:0] pr; logic pl; logic [IDW-1:0] pi;
    logic [DW-1:0] ed; logic [1:0] er; string dreq;
    @(negedge clk);
    check(ar_ready == 1'b1, "R2", "ready before request", 64'(ar_ready), 64'd1);
    ar_valid = 1'b1; ar_id = IDW'(id); ar_addr = AW'(addr);
    ar_len = 8'(len); ar_size = 3'(sz); ar_burst = 2'(bt);
    @(negedge clk);
    ar_valid = 1'b0;
    ea = addr; beat = 0; guard = 0; stalled = 1'b0;
    pd = '0; pr = '0; pl = 1'b0; pi = '0;
    while (beat <= len && guard < 5000) begin
      check(r_valid == 1'b1, (beat == 0 && guard == 0) ? "R4" : "R3", "valid in burst",
            64'(r_valid), 64'd1);
      check(ar_ready == 1'b0, "R2", "ready during burst", 64'(ar_ready), 64'd0);
      if (stalled)
        check(r_data == pd && r_resp == pr && r_last == pl && r_id == pi, "R8",
              "held beat", {r_data, 30'(r_resp), r_last, 1'b0}, {pd, 30'(pr), pl, 1'b0});
      if (ea < TOP) begin
        ed = exp_word(ea >> 2); er = 2'b00;
        dreq = (bt == 0) ? "R6/R11" : (bt == 2) ? "R7/R11" : "R5/R11";
      end else begin
        ed = '0; er = 2'b11; dreq = "R9";
      end
      check(r_resp == er, "R9", "response", 64'(r_resp), 64'(er));
      check(r_data == ed, dreq, $sformatf("data beat %0d addr %0h", beat, ea),
            64'(r_data), 64'(ed));
      check(r_last == (beat == len), "R3", $sformatf("last flag beat %0d", beat),
            64'(r_last), 64'(beat == len));
      check(r_id == IDW'(id), "R10", "id", 64'(r_id), 64'(id));
      r_ready = ($urandom_range(99) < rdy_pct);
      stalled = !r_ready;
      pd = r_data; pr = r_resp; pl = r_last; pi = r_id;
      if (r_ready) begin
        beat++;
        ea = exp_next(ea, sz, bt, len);
      end
      @(negedge clk);
      guard++;
    end
    r_ready = 1'b0;
    check(beat == len + 1, "R3", "beat count", 64'(beat), 64'(len + 1));
    check(r_valid == 1'b0, "R2", "valid after last", 64'(r_valid), 64'd0);
    check(ar_ready == 1'b1, "R2", "ready after last", 64'(ar_ready), 64'd1);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bt, sz, ln, ad, lens[4];
    lens = '{1, 3, 7, 15};
    void'($urandom(32'd5150));
    @(negedge clk);
    check(ar_ready == 1'b1 && r_valid == 1'b0 && r_last == 1'b0, "R1", "state in reset",
          {ar_ready, r_valid, r_last}, 64'b100);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ar_ready == 1'b1 && r_valid == 1'b0 && r_last == 1'b0, "R1", "state after reset",
          {ar_ready, r_valid, r_last}, 64'b100);
    // Directed corners
    run_burst(1, 0, 255, 2, 1, 80);       // R5 full-length burst ending at the top
    run_burst(2, 16'h3F8, 3, 2, 1, 50);   // R9 decode switches mid-burst
    run_burst(3, 16'h1C, 3, 2, 2, 60);    // R7 wraps after first beat
    run_burst(4, 16'h44, 5, 2, 0, 40);    // R6 repeated address
    run_burst(5, 16'h21, 7, 0, 1, 100);   // R5 byte steps
    run_burst(6, 16'h500, 0, 2, 1, 30);   // R9 single decode-error beat
    run_burst(7, 16'h7E, 7, 1, 2, 70);    // R7 halfword wrap
    // Random mix
    for (int n = 0; n < 60; n++) begin
      bt = $urandom_range(2);
      sz = $urandom_range(2);
      ln = (bt == 2) ? lens[$urandom_range(3)] : $urandom_range(20);
      ad = $urandom_range(1100) & ~((1 << sz) - 1);
      run_burst($urandom_range(15), ad, ln, sz, bt, $urandom_range(30, 100));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule